// File: doc/BRIEF.md
# Aggregated Bitmap Set Tree

This block holds a set drawn from a universe of `N` indices. Membership lives in a bitmap cut into `W`-bit leaf words. Above the leaf words sits a binary summary tree. Every internal node of that tree keeps two population counts: the number of members under its left child and the number under its right child. Each tree level has its own register bank. Every request walks from the root to the leaves one level per clock, so a new request can enter on every cycle while older ones are still finishing lower in the tree.

Four operations are offered. Add, delete and test each take an index. Find returns a member without scanning the bitmap: it follows the population counts down to a non-empty leaf word and picks the lowest set bit in that word. Because each step prefers the left side, the member returned is always the smallest one in the set.

Add and delete change the counts on their path only when the membership bit actually flips. The bit is settled when the request is issued. The leaf bank is read at that point and then overridden by any add or delete to the same index that is still in the pipeline, so a redundant add or delete leaves every count untouched. The defaults are `N = 128` and `W = 16`, which gives three count levels and a response latency of four edges. `N` and `W` must be powers of two, with `N` at least `2*W`.

Top module: `abset_tree`

## Requirements
- R1: After reset the set is empty, `req_ready` is high from the first rising edge after reset is released, and `rsp_valid` stays low until a request has been accepted.
- R2: A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. Each accepted request produces exactly one response cycle with `rsp_valid` high. That response is visible after the log2(N/W)+1'th rising edge, counting the accepting edge as the first (the fourth edge for the defaults). Responses come out in request order, and `rsp_op` echoes the request's operation code.
- R3: Add (operation code 1) makes the index a member. `rsp_idx` echoes the index, and `rsp_hit` reports whether the index was a member before the add.
- R4: Delete (operation code 2) removes the index from the set. `rsp_idx` echoes the index, and `rsp_hit` reports whether the index was a member before the delete.
- R5: Test (operation code 0) leaves the set unchanged. `rsp_idx` echoes the index, and `rsp_hit` reports membership as left by all earlier accepted requests.
- R6: An add of an existing member, or a delete of a non-member, changes neither the set nor any count. Later finds and tests answer exactly as if that request had never been issued.
- R7: Find (operation code 3) on a non-empty set returns `rsp_hit` = 1, `rsp_empty` = 0, and in `rsp_idx` the smallest member of the set.
- R8: Find on an empty set returns `rsp_empty` = 1, `rsp_hit` = 0 and `rsp_idx` = 0. `rsp_empty` is 0 on every other response.
- R9: Requests may be issued on consecutive cycles. Each request observes the effect of every earlier request, including requests to the same index that are still in flight.
- R10: The membership decision taken at issue always agrees with the leaf bit found when the request reaches the leaf. No node's total exceeds the size of its subtree. The root total moves by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request this cycle |
| req_op | input | 2 | Operation: 0 test, 1 add, 2 delete, 3 find |
| req_idx | input | log2(N) | Element index (ignored for find) |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_op | output | 2 | Operation code of the answered request |
| rsp_idx | output | log2(N) | Echoed index, or the member found by find |
| rsp_hit | output | 1 | Prior membership (test/add/delete) or member found (find) |
| rsp_empty | output | 1 | Find saw an empty set |

## Verification
The assertions act on every cycle. They check the following:
- each accepted request has exactly one response, at the fixed latency;
- the membership flag computed at issue, with its forwarding from in-flight requests, matches the leaf bit read later;
- a find that is not empty always lands on a non-zero leaf word;
- the per-level counts stay within their subtree sizes;
- the root population changes by at most one per cycle.

Whether the answers are right is shown only by the bench scenarios. These cover the smallest member returned by find, redundant adds and deletes leaving the counts intact, same-index requests issued back to back, and draining a full set down to empty.

// File: rtl/abt_pkg.sv
package abt_pkg;

    typedef enum logic [1:0] {
        OP_TEST = 2'd0,
        OP_ADD  = 2'd1,
        OP_DEL  = 2'd2,
        OP_FIND = 2'd3
    } abt_op_e;

endpackage

// File: rtl/abt_fwd.sv
// Issue-time membership: leaf bit overridden by younger in-flight updates.
module abt_fwd
    import abt_pkg::*;
#(
    parameter int IW = 7,
    parameter int D  = 3
) (
    input  abt_op_e           req_op,
    input  logic [IW-1:0]     req_idx,
    input  logic              peek_bit,
    input  logic              st_v   [D],
    input  abt_op_e           st_op  [D],
    input  logic [IW-1:0]     st_idx [D],
    output logic              chg
);

    logic prior;

    always_comb begin
        prior = peek_bit;
        // oldest stage first so that the youngest matching update wins
        for (int s = D - 1; s >= 0; s--) begin
            if (st_v[s] && (st_idx[s] == req_idx)) begin
                if (st_op[s] == OP_ADD) begin
                    prior = 1'b1;
                end else if (st_op[s] == OP_DEL) begin
                    prior = 1'b0;
                end
            end
        end
        chg = ((req_op == OP_ADD) && !prior) || ((req_op == OP_DEL) && prior);
    end

endmodule

// File: rtl/abt_level.sv
// One count level of the tree: own bank, one read and one write per cycle.
module abt_level
    import abt_pkg::*;
#(
    parameter int N   = 128,
    parameter int IW  = 7,
    parameter int LVL = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_v,
    input  abt_op_e        in_op,
    input  logic [IW-1:0]  in_idx,
    input  logic           in_chg,
    input  logic           in_emp,
    output logic           out_v,
    output abt_op_e        out_op,
    output logic [IW-1:0]  out_idx,
    output logic           out_chg,
    output logic           out_emp,
    output logic [IW:0]    rd_tot
);

    localparam int NB    = (LVL == 0) ? 1 : LVL;
    localparam int DEPTH = 1 << NB;
    localparam int CW    = $clog2(N >> (LVL + 1)) + 1;
    localparam int BR    = IW - 1 - LVL;

    logic [CW-1:0] lcnt [DEPTH];
    logic [CW-1:0] rcnt [DEPTH];

    logic [NB-1:0] node;
    logic [CW-1:0] lv;
    logic [CW-1:0] rv;
    logic          br;
    logic          upd;
    logic          emp_now;
    logic [IW-1:0] nidx;

    always_comb begin
        node    = NB'(in_idx >> (IW - LVL));
        lv      = lcnt[node];
        rv      = rcnt[node];
        emp_now = (LVL == 0) && (lv == '0) && (rv == '0);
        if (in_op == OP_FIND) begin
            br = (lv == '0);
        end else begin
            br = in_idx[BR];
        end
        nidx     = in_idx;
        nidx[BR] = br;
        upd      = in_v && in_chg && ((in_op == OP_ADD) || (in_op == OP_DEL));
        rd_tot   = (IW+1)'(lv) + (IW+1)'(rv);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) begin
                lcnt[j] <= '0;
                rcnt[j] <= '0;
            end
            out_v   <= 1'b0;
            out_op  <= OP_TEST;
            out_idx <= '0;
            out_chg <= 1'b0;
            out_emp <= 1'b0;
        end else begin
            if (upd) begin
                if (!br) begin
                    lcnt[node] <= (in_op == OP_ADD) ? lcnt[node] + CW'(1)
                                                    : lcnt[node] - CW'(1);
                end else begin
                    rcnt[node] <= (in_op == OP_ADD) ? rcnt[node] + CW'(1)
                                                    : rcnt[node] - CW'(1);
                end
            end
            out_v   <= in_v;
            out_op  <= in_op;
            out_idx <= nidx;
            out_chg <= in_chg;
            out_emp <= in_emp || ((in_op == OP_FIND) && emp_now);
        end
    end

endmodule

// File: rtl/abt_leaf.sv
// Leaf bitmap bank: final read-modify-write and response register.
module abt_leaf
    import abt_pkg::*;
#(
    parameter int N  = 128,
    parameter int W  = 16,
    parameter int IW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_v,
    input  abt_op_e        in_op,
    input  logic [IW-1:0]  in_idx,
    input  logic           in_emp,
    input  logic [IW-1:0]  peek_idx,
    output logic           peek_bit,
    output logic           cur_bit,
    output logic           word_nz,
    output logic           rsp_v,
    output logic [1:0]     rsp_op,
    output logic [IW-1:0]  rsp_idx,
    output logic           rsp_hit,
    output logic           rsp_emp
);

    localparam int LW = $clog2(W);
    localparam int L  = N / W;
    localparam int WB = IW - LW;

    logic [W-1:0]  words [L];
    logic [WB-1:0] wsel;
    logic [LW-1:0] bsel;
    logic [W-1:0]  wv;
    logic [W-1:0]  nwv;
    logic [LW-1:0] lo;
    logic [W-1:0]  pw;

    always_comb begin
        wsel    = in_idx[IW-1:LW];
        bsel    = in_idx[LW-1:0];
        wv      = words[wsel];
        cur_bit = wv[bsel];
        word_nz = |wv;
        lo      = '0;
        for (int b = W - 1; b >= 0; b--) begin
            if (wv[b]) begin
                lo = LW'(b);
            end
        end
        nwv = wv;
        if (in_op == OP_ADD) begin
            nwv[bsel] = 1'b1;
        end else if (in_op == OP_DEL) begin
            nwv[bsel] = 1'b0;
        end
        pw       = words[peek_idx[IW-1:LW]];
        peek_bit = pw[peek_idx[LW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < L; j++) begin
                words[j] <= '0;
            end
            rsp_v   <= 1'b0;
            rsp_op  <= 2'd0;
            rsp_idx <= '0;
            rsp_hit <= 1'b0;
            rsp_emp <= 1'b0;
        end else begin
            if (in_v && ((in_op == OP_ADD) || (in_op == OP_DEL))) begin
                words[wsel] <= nwv;
            end
            rsp_v  <= in_v;
            rsp_op <= in_op;
            if (in_op == OP_FIND) begin
                rsp_idx <= in_emp ? '0 : {wsel, lo};
                rsp_hit <= !in_emp;
                rsp_emp <= in_emp;
            end else begin
                rsp_idx <= in_idx;
                rsp_hit <= cur_bit;
                rsp_emp <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/abset_tree.sv
// Pipelined set with per-node left/right population counts.
module abset_tree
    import abt_pkg::*;
#(
    parameter int N = 128,
    parameter int W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [1:0]             req_op,
    input  logic [$clog2(N)-1:0]   req_idx,
    output logic                   rsp_valid,
    output logic [1:0]             rsp_op,
    output logic [$clog2(N)-1:0]   rsp_idx,
    output logic                   rsp_hit,
    output logic                   rsp_empty
);

    localparam int IW  = $clog2(N);
    localparam int L   = N / W;
    localparam int D   = $clog2(L);
    localparam int LAT = D + 1;

    logic          ready_q;
    logic          r_v;
    abt_op_e       r_op;
    logic          r_chg;

    logic          s_v   [D];
    abt_op_e       s_op  [D];
    logic [IW-1:0] s_idx [D];
    logic          s_chg [D];
    logic          s_emp [D];
    logic [IW:0]   lvl_tot [D];

    logic          peek_bit;
    logic          leaf_bit;
    logic          leaf_nz;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    assign req_ready = ready_q;
    assign r_v       = req_valid && ready_q;
    assign r_op      = abt_op_e'(req_op);

    abt_fwd #(.IW(IW), .D(D)) u_fwd (
        .req_op   (r_op),
        .req_idx  (req_idx),
        .peek_bit (peek_bit),
        .st_v     (s_v),
        .st_op    (s_op),
        .st_idx   (s_idx),
        .chg      (r_chg)
    );

    for (genvar k = 0; k < D; k++) begin : g_lvl
        if (k == 0) begin : g_root
            abt_level #(.N(N), .IW(IW), .LVL(k)) u_lvl (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_v    (r_v),
                .in_op   (r_op),
                .in_idx  (req_idx),
                .in_chg  (r_chg),
                .in_emp  (1'b0),
                .out_v   (s_v[k]),
                .out_op  (s_op[k]),
                .out_idx (s_idx[k]),
                .out_chg (s_chg[k]),
                .out_emp (s_emp[k]),
                .rd_tot  (lvl_tot[k])
            );
        end else begin : g_inner
            abt_level #(.N(N), .IW(IW), .LVL(k)) u_lvl (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_v    (s_v[k-1]),
                .in_op   (s_op[k-1]),
                .in_idx  (s_idx[k-1]),
                .in_chg  (s_chg[k-1]),
                .in_emp  (s_emp[k-1]),
                .out_v   (s_v[k]),
                .out_op  (s_op[k]),
                .out_idx (s_idx[k]),
                .out_chg (s_chg[k]),
                .out_emp (s_emp[k]),
                .rd_tot  (lvl_tot[k])
            );
        end
    end

    abt_leaf #(.N(N), .W(W), .IW(IW)) u_leaf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_v     (s_v[D-1]),
        .in_op    (s_op[D-1]),
        .in_idx   (s_idx[D-1]),
        .in_emp   (s_emp[D-1]),
        .peek_idx (req_idx),
        .peek_bit (peek_bit),
        .cur_bit  (leaf_bit),
        .word_nz  (leaf_nz),
        .rsp_v    (rsp_valid),
        .rsp_op   (rsp_op),
        .rsp_idx  (rsp_idx),
        .rsp_hit  (rsp_hit),
        .rsp_emp  (rsp_empty)
    );

endmodule

// File: rtl/abt_chk.sv
module abt_chk
    import abt_pkg::*;
#(
    parameter int N   = 128,
    parameter int IW  = 7,
    parameter int D   = 3,
    parameter int LAT = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_ready,
    input  logic           rsp_valid,
    input  logic [1:0]     rsp_op,
    input  logic           rsp_hit,
    input  logic           rsp_empty,
    input  logic           leaf_v,
    input  abt_op_e        leaf_op,
    input  logic           leaf_chg,
    input  logic           leaf_bit,
    input  logic           leaf_emp,
    input  logic           leaf_nz,
    input  logic [IW:0]    lvl_tot [D]
);

    logic [LAT-1:0] acc_sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_sh <= '0;
        end else begin
            acc_sh <= {acc_sh[LAT-2:0], req_valid && req_ready};
        end
    end

    // R1 R2: one response per accepted request, at the fixed latency
    a_r2_one_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == acc_sh[LAT-1]);

    // R10: issue-time decision agrees with the leaf bit
    a_r10_fwd_leaf: assert property (@(posedge clk) disable iff (!rst_n)
        (leaf_v && (leaf_op == OP_ADD)) |-> (leaf_chg == !leaf_bit));

    a_r10_fwd_leaf_del: assert property (@(posedge clk) disable iff (!rst_n)
        (leaf_v && (leaf_op == OP_DEL)) |-> (leaf_chg == leaf_bit));

    // R7: a non-empty find always reaches a populated leaf word
    a_r7_find_word: assert property (@(posedge clk) disable iff (!rst_n)
        (leaf_v && (leaf_op == OP_FIND) && !leaf_emp) |-> leaf_nz);

    // R8: the empty flag belongs to finds only
    a_r8_empty_find: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_empty) |-> ((rsp_op == 2'd3) && !rsp_hit));

    // R10: root population moves by at most one per cycle
    a_r10_root_step: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_tot[0] >= $past(lvl_tot[0])) ? ((lvl_tot[0] - $past(lvl_tot[0])) <= 1)
                                          : (($past(lvl_tot[0]) - lvl_tot[0]) <= 1));

    // R10: no node total exceeds its subtree size
    for (genvar k = 0; k < D; k++) begin : g_bound
        a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_tot[k] <= (IW+1)'(N >> k));
    end

endmodule

bind abset_tree abt_chk #(.N(N), .IW(IW), .D(D), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_op    (rsp_op),
    .rsp_hit   (rsp_hit),
    .rsp_empty (rsp_empty),
    .leaf_v    (s_v[D-1]),
    .leaf_op   (s_op[D-1]),
    .leaf_chg  (s_chg[D-1]),
    .leaf_bit  (leaf_bit),
    .leaf_emp  (s_emp[D-1]),
    .leaf_nz   (leaf_nz),
    .lvl_tot   (lvl_tot)
);

// File: tb/sim_abset_tree.sv
module sim_abset_tree;

    localparam int N   = 128;
    localparam int W   = 16;
    localparam int IW  = 7;
    localparam int LAT = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [1:0]    req_op;
    logic [IW-1:0] req_idx;
    logic          rsp_valid;
    logic [1:0]    rsp_op;
    logic [IW-1:0] rsp_idx;
    logic          rsp_hit;
    logic          rsp_empty;

    always #10 clk = ~clk;

    abset_tree #(.N(N), .W(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_idx   (req_idx),
        .rsp_valid (rsp_valid),
        .rsp_op    (rsp_op),
        .rsp_idx   (rsp_idx),
        .rsp_hit   (rsp_hit),
        .rsp_empty (rsp_empty)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done  = 0;
    string scen  = "reset";
    bit    model [N];
    int    q_due[$];
    int    q_op[$];
    int    q_idx[$];
    int    q_hit[$];
    int    q_emp[$];

    task automatic chk(bit ok, string req, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] cycle %0d actual=%0d expected=%0d", req, scen, cyc, act, exp);
        end
    endtask

    function automatic string op_req(int op, int emp);
        if (op == 0) return "R5";
        if (op == 1) return "R3";
        if (op == 2) return "R4";
        return emp ? "R8" : "R7";
    endfunction

    task automatic model_apply(int op, int idx);
        int h = 0;
        int e = 0;
        int x = idx;
        case (op)
            0: h = model[idx];
            1: begin h = model[idx]; model[idx] = 1'b1; end
            2: begin h = model[idx]; model[idx] = 1'b0; end
            default: begin
                x = -1;
                for (int j = N - 1; j >= 0; j--) begin
                    if (model[j]) x = j;
                end
                if (x < 0) begin x = 0; e = 1; h = 0; end
                else h = 1;
            end
        endcase
        q_due.push_back(cyc + LAT - 1);
        q_op.push_back(op);
        q_idx.push_back(x);
        q_hit.push_back(h);
        q_emp.push_back(e);
    endtask

    task automatic compare();
        if (q_due.size() > 0 && q_due[0] == cyc) begin
            int eo = q_op.pop_front();
            int ei = q_idx.pop_front();
            int eh = q_hit.pop_front();
            int ee = q_emp.pop_front();
            string t = op_req(eo, ee);
            void'(q_due.pop_front());
            chk(rsp_valid == 1'b1, "R2", int'(rsp_valid), 1);
            chk(int'(rsp_op) == eo, "R2", int'(rsp_op), eo);
            chk(int'(rsp_idx) == ei, t, int'(rsp_idx), ei);
            chk(int'(rsp_hit) == eh, t, int'(rsp_hit), eh);
            chk(int'(rsp_empty) == ee, "R8", int'(rsp_empty), ee);
        end else begin
            chk(rsp_valid == 1'b0, "R2", int'(rsp_valid), 0);
        end
    endtask

    task automatic step(bit v, int op, int idx);
        bit acc;
        @(negedge clk);
        req_valid = v;
        req_op    = 2'(op);
        req_idx   = IW'(idx);
        acc       = v && req_ready;
        @(posedge clk);
        cyc++;
        if (acc) model_apply(op, idx);
        #1;
        compare();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(1'b0, 0, 0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        for (int j = 0; j < N; j++) model[j] = 1'b0;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_op    = 2'd0;
        req_idx   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1: ready after the first edge out of reset, nothing pending
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);

        // R1 R8: empty set after reset
        scen = "R1 R8 empty";
        step(1, 0, 0);
        step(1, 0, 5);
        step(1, 0, 127);
        step(1, 3, 0);
        idle(LAT);

        // R3 R4 R5 R7: basic membership and smallest member
        scen = "R3 R4 R5 R7 basic";
        step(1, 1, 3);
        step(1, 1, 40);
        step(1, 1, 127);
        step(1, 1, 64);
        step(1, 0, 3);
        step(1, 0, 4);
        step(1, 0, 127);
        step(1, 3, 0);
        step(1, 2, 3);
        step(1, 3, 0);
        idle(LAT);

        // R9 R6: same index back to back while earlier requests are in flight
        scen = "R9 R6 back-to-back";
        step(1, 1, 10);
        step(1, 0, 10);
        step(1, 2, 10);
        step(1, 0, 10);
        step(1, 1, 10);
        step(1, 1, 10);
        step(1, 3, 0);
        step(1, 2, 10);
        step(1, 2, 10);
        step(1, 3, 0);
        idle(LAT);

        // R6: redundant updates must not disturb the counts
        scen = "R6 redundant";
        step(1, 1, 40);
        step(1, 1, 40);
        step(1, 2, 5);
        step(1, 2, 5);
        step(1, 2, 40);
        step(1, 2, 64);
        step(1, 3, 0);
        step(1, 2, 127);
        step(1, 3, 0);
        step(1, 0, 40);
        idle(LAT);

        // R7 R8: fill every index, then drain from the bottom
        scen = "R7 R8 sweep";
        for (int i = 0; i < N; i++) step(1, 1, i);
        for (int i = 0; i < N; i++) begin
            step(1, 3, 0);
            step(1, 2, i);
        end
        step(1, 3, 0);
        idle(LAT);

        // R2 R9 R10: mixed stream with gaps and heavy index reuse
        scen = "R2 R9 R10 stream";
        r = 32'h1234_5678;
        for (int k = 0; k < 4000; k++) begin
            r = r * 32'd1103515245 + 32'd12345;
            step(r[20] | r[21], int'(r[25:24]), int'({r[18:16], 2'b00, r[9:8]}));
        end
        idle(LAT + 2);

        done = 1;
        summary();
        $finish;
    end

endmodule